// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Flag Unit

This block is the purely combinational arithmetic core of a small 8-bit processor. The datapath puts an operation code and its operands on the inputs: accumulator, memory or second operand, the X register, and the current carry. In the same cycle the block returns the result and four flag values: negative (N), overflow (V), zero (Z) and carry (C). Each flag has its own write enable. The status register loads only the flags whose enable is high, so flags that an operation does not touch keep their old values without any extra logic at the register.

Arithmetic is binary only. No decimal-mode input exists, so a decimal flag held elsewhere has no effect on any result. Besides the usual add, subtract, compare, logic, bit test, shift, rotate, increment, decrement, load and move operations, the block also provides four combined operations. Each of these first ANDs the accumulator with the operand and then applies a further step with an unusual flag rule: AND-to-carry, AND-and-rotate, masked subtract, and AND-and-shift. Unary operations (shifts, rotates, increment, decrement, load, move) act on operand B. The datapath routes the accumulator to B when an operation targets the accumulator.

Top module: `byte_alu`

## Requirements
- R1: Code 0 (add) returns R = A+B+Cin modulo 256. C is bit 8 of the 9-bit sum. V is bit 7 of (A^R)&(B^R). N is R bit 7 and Z is R==0. All four enables are high.
- R2: Code 1 (subtract) returns R = A-B-(1-Cin) modulo 256. C is high when no borrow occurs (A >= B+(1-Cin)). V is bit 7 of (A^B)&(A^R). N and Z follow R, and all four enables are high.
- R3: Code 2 (compare) returns A-B. C is high when A >= B (unsigned), and N and Z follow the difference. The N, Z and C enables are high and the V enable is low.
- R4: Codes 3, 4 and 5 return A&B, A|B and A^B. Only the N and Z enables are high, with N as result bit 7 and Z as result==0.
- R5: Code 6 (bit test) returns A&B. N is B bit 7, V is B bit 6, and Z is (A&B)==0. The N, V and Z enables are high and the C enable is low.
- R6: Code 7 shifts B left with a 0 fill. Code 8 shifts B right with a 0 fill. In both, C takes the bit shifted out, N and Z follow the result, and the N, Z and C enables are high.
- R7: Code 9 rotates B left, with Cin entering bit 0. Code 10 rotates B right, with Cin entering bit 7. In both, C takes the bit shifted out and the N, Z and C enables are high.
- R8: Code 11 returns B+1, code 12 returns B-1 (both modulo 256), and code 13 returns B unchanged. Only the N and Z enables are high.
- R9: Code 14 (move) returns B unchanged and raises no enable.
- R10: Code 15 returns A&B with N and Z from the result, and C equal to result bit 7. The N, Z and C enables are high.
- R11: Code 16 forms T=A&B and returns {Cin, T[7:1]}. N and Z follow the result, C is result bit 6, and V is result bit 6 XOR bit 5. All four enables are high.
- R12: Code 17 returns (A&X)-B modulo 256. C is high when no borrow occurs, N and Z follow the result, and the N, Z and C enables are high. The X input affects no other code.
- R13: Code 18 forms T=A&B and returns T shifted right by one with a 0 fill. C is T bit 0, N and Z follow the result, and the N, Z and C enables are high.
- R14: A flag output whose enable is low reads 0, except C, which repeats Cin. Codes 19 to 31 return A and raise no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand or memory data |
| x_i | input | 8 | Index register operand (masked subtract only) |
| c_i | input | 1 | Carry in |
| res_o | output | 8 | Result |
| n_o | output | 1 | Negative flag value |
| v_o | output | 1 | Overflow flag value |
| z_o | output | 1 | Zero flag value |
| c_o | output | 1 | Carry flag value |
| n_we_o | output | 1 | Negative flag write enable |
| v_we_o | output | 1 | Overflow flag write enable |
| z_we_o | output | 1 | Zero flag write enable |
| c_we_o | output | 1 | Carry flag write enable |

## Verification
Every output of this block is due in the same cycle as its stimulus, with zero register stages between any input and any output. The bench therefore changes the inputs just after a falling clock edge and reads all outputs one nanosecond later, well before the next rising edge. This way each check sees only the settled response to the values just driven. The table vectors, the add, subtract and compare sweeps, and the directed X-independence checks all follow this drive-then-sample rule.

// File: rtl/byte_alu_pkg.sv
// Package byte_alu_pkg
// Holds the shared operation codes and flag bundle used by the ALU units.
// Assumes a 5-bit operation select; codes above ALU_ASR are unused.
package byte_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD  = 5'd0,
        ALU_SUB  = 5'd1,
        ALU_CMP  = 5'd2,
        ALU_AND  = 5'd3,
        ALU_OR   = 5'd4,
        ALU_XOR  = 5'd5,
        ALU_BIT  = 5'd6,
        ALU_ASL  = 5'd7,
        ALU_LSR  = 5'd8,
        ALU_ROL  = 5'd9,
        ALU_ROR  = 5'd10,
        ALU_INC  = 5'd11,
        ALU_DEC  = 5'd12,
        ALU_LOAD = 5'd13,
        ALU_MOVE = 5'd14,
        ALU_AAC  = 5'd15,
        ALU_ARR  = 5'd16,
        ALU_AXS  = 5'd17,
        ALU_ASR  = 5'd18
    } alu_op_e;

    localparam int LAST_OP = 18;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/byte_alu_arith.sv
// Module byte_alu_arith
// One shared carry adder serves add, subtract, compare, masked subtract,
// increment and decrement. Subtraction adds the inverted operand plus carry.
// Assumes W >= 2. Raises hit_o only for the codes it owns.
module byte_alu_arith
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [W-1:0]    x_i,
    input  logic            c_i,
    output logic [W-1:0]    res_o,
    output alu_flags_t      flg_o,
    output alu_flags_t      we_o,
    output logic            hit_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    logic         cin;
    logic [W:0]   sum;
    logic [W-1:0] r;

    // Pick the adder inputs and flag enables for the current code.
    always_comb begin
        lhs   = a_i;
        rhs   = ~b_i;
        cin   = 1'b1;
        hit_o = 1'b1;
        we_o  = '0;
        case (alu_op_e'(op_i))
            ALU_ADD: begin
                rhs  = b_i;
                cin  = c_i;
                we_o = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
            end
            ALU_SUB: begin
                cin  = c_i;
                we_o = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
            end
            ALU_CMP: begin
                we_o = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
            end
            ALU_AXS: begin
                lhs  = a_i & x_i;
                we_o = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
            end
            ALU_INC: begin
                lhs  = b_i;
                rhs  = '0;
                we_o = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
            end
            ALU_DEC: begin
                lhs  = b_i;
                rhs  = '1;
                cin  = 1'b0;
                we_o = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
            end
            default: begin
                hit_o = 1'b0;
            end
        endcase
    end

    // Single carry chain shared by every code of this unit.
    always_comb begin
        sum = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin};
        r   = sum[W-1:0];
    end

    // Flags; overflow uses the adder operands so one formula covers add and subtract.
    always_comb begin
        res_o   = r;
        flg_o.n = r[MSB];
        flg_o.z = (r == '0);
        flg_o.c = sum[W];
        flg_o.v = (lhs[MSB] ^ r[MSB]) & (rhs[MSB] ^ r[MSB]);
    end

endmodule

// File: rtl/byte_alu_shift.sv
// Module byte_alu_shift
// Shifts and rotates of B, plus the two combined codes that first AND A
// with B (AND-and-rotate, AND-and-shift). Assumes W >= 3 so that bits 6
// and 5 of the rotate result exist.
module byte_alu_shift
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            c_i,
    output logic [W-1:0]    res_o,
    output alu_flags_t      flg_o,
    output alu_flags_t      we_o,
    output logic            hit_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] src;
    logic         masked;
    logic         left;
    logic         fill;
    logic [W-1:0] r;
    logic         out_bit;

    // Decode direction, fill bit and whether the source is A AND B.
    always_comb begin
        masked = 1'b0;
        left   = 1'b0;
        fill   = 1'b0;
        hit_o  = 1'b1;
        we_o   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
        case (alu_op_e'(op_i))
            ALU_ASL: left = 1'b1;
            ALU_LSR: fill = 1'b0;
            ALU_ROL: begin
                left = 1'b1;
                fill = c_i;
            end
            ALU_ROR: fill = c_i;
            ALU_ARR: begin
                masked = 1'b1;
                fill   = c_i;
                we_o   = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
            end
            ALU_ASR: masked = 1'b1;
            default: begin
                hit_o = 1'b0;
                we_o  = '0;
            end
        endcase
    end

    // One-position shifter with selectable fill.
    always_comb begin
        src = masked ? (a_i & b_i) : b_i;
        if (left) begin
            r       = {src[MSB-1:0], fill};
            out_bit = src[MSB];
        end else begin
            r       = {fill, src[MSB:1]};
            out_bit = src[0];
        end
    end

    // Flags; the AND-and-rotate code takes C and V from the result bits.
    always_comb begin
        res_o   = r;
        flg_o.n = r[MSB];
        flg_o.z = (r == '0);
        if (alu_op_e'(op_i) == ALU_ARR) begin
            flg_o.c = r[MSB-1];
            flg_o.v = r[MSB-1] ^ r[MSB-2];
        end else begin
            flg_o.c = out_bit;
            flg_o.v = 1'b0;
        end
    end

endmodule

// File: rtl/byte_alu_logic.sv
// Module byte_alu_logic
// Bitwise codes, bit test, load, move and AND-to-carry.
// Assumes W >= 2 so bit test can read the two top operand bits.
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    res_o,
    output alu_flags_t      flg_o,
    output alu_flags_t      we_o,
    output logic            hit_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] r;

    // Result and enables per code.
    always_comb begin
        hit_o = 1'b1;
        we_o  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
        r     = b_i;
        case (alu_op_e'(op_i))
            ALU_AND:  r = a_i & b_i;
            ALU_OR:   r = a_i | b_i;
            ALU_XOR:  r = a_i ^ b_i;
            ALU_BIT: begin
                r    = a_i & b_i;
                we_o = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
            end
            ALU_LOAD: r = b_i;
            ALU_MOVE: begin
                r    = b_i;
                we_o = '0;
            end
            ALU_AAC: begin
                r    = a_i & b_i;
                we_o = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
            end
            default: begin
                hit_o = 1'b0;
                we_o  = '0;
            end
        endcase
    end

    // Flags; bit test reads N and V from the operand, not the result.
    always_comb begin
        res_o   = r;
        flg_o.z = (r == '0);
        flg_o.c = r[MSB];
        if (alu_op_e'(op_i) == ALU_BIT) begin
            flg_o.n = b_i[MSB];
            flg_o.v = b_i[MSB-1];
        end else begin
            flg_o.n = r[MSB];
            flg_o.v = 1'b0;
        end
    end

endmodule

// File: rtl/byte_alu.sv
// Module byte_alu
// Combinational ALU top: three operation units, a select by owning unit,
// and flag masking so a disabled flag reads 0 (C repeats carry in).
// Unused codes pass A and raise no enable. Binary arithmetic only.
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [4:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] x_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         n_o,
    output logic         v_o,
    output logic         z_o,
    output logic         c_o,
    output logic         n_we_o,
    output logic         v_we_o,
    output logic         z_we_o,
    output logic         c_we_o
);

    localparam int N_UNIT = 3;

    logic [W-1:0] u_res [N_UNIT];
    alu_flags_t   u_flg [N_UNIT];
    alu_flags_t   u_we  [N_UNIT];
    logic [N_UNIT-1:0] u_hit;

    logic [W-1:0] sel_res;
    alu_flags_t   sel_flg;
    alu_flags_t   sel_we;

    byte_alu_arith #(.W(W)) u_arith (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .x_i   (x_i),
        .c_i   (c_i),
        .res_o (u_res[0]),
        .flg_o (u_flg[0]),
        .we_o  (u_we[0]),
        .hit_o (u_hit[0])
    );

    byte_alu_shift #(.W(W)) u_shift (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .c_i   (c_i),
        .res_o (u_res[1]),
        .flg_o (u_flg[1]),
        .we_o  (u_we[1]),
        .hit_o (u_hit[1])
    );

    byte_alu_logic #(.W(W)) u_logic (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (u_res[2]),
        .flg_o (u_flg[2]),
        .we_o  (u_we[2]),
        .hit_o (u_hit[2])
    );

    // Take the output of whichever unit owns the code; otherwise pass A.
    always_comb begin
        sel_res = a_i;
        sel_flg = '0;
        sel_we  = '0;
        for (int i = 0; i < N_UNIT; i++) begin
            if (u_hit[i]) begin
                sel_res = u_res[i];
                sel_flg = u_flg[i];
                sel_we  = u_we[i];
            end
        end
    end

    // Mask flags that are not written; carry repeats its input.
    always_comb begin
        res_o  = sel_res;
        n_we_o = sel_we.n;
        v_we_o = sel_we.v;
        z_we_o = sel_we.z;
        c_we_o = sel_we.c;
        n_o    = sel_we.n & sel_flg.n;
        v_o    = sel_we.v & sel_flg.v;
        z_o    = sel_we.z & sel_flg.z;
        c_o    = sel_we.c ? sel_flg.c : c_i;
    end

endmodule

// File: rtl/byte_alu_chk.sv
// Module byte_alu_chk
// Port-level checks on the ALU, bound to every instance of byte_alu.
// Purely combinational: checks are skipped while any input is unknown.
module byte_alu_chk #(
    parameter int W = 8
) (
    input logic [4:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] x_i,
    input logic         c_i,
    input logic [W-1:0] res_o,
    input logic         n_o,
    input logic         v_o,
    input logic         z_o,
    input logic         c_o,
    input logic         n_we_o,
    input logic         v_we_o,
    input logic         z_we_o,
    input logic         c_we_o
);

    localparam int MSB = W - 1;

    logic [W:0]   add_ref;
    logic [W:0]   sub_need;
    logic [W-1:0] sub_ref;

    // Reference sums written from the requirement wording.
    always_comb begin
        add_ref  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};
        sub_need = {1'b0, b_i} + {{W{1'b0}}, ~c_i};
        sub_ref  = a_i - b_i - {{(W-1){1'b0}}, ~c_i};
    end

    // All port relations, evaluated whenever an input changes.
    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, x_i, c_i})) begin
            if (op_i == 5'd0) begin
                p_add_sum_r1: assert ({c_o, res_o} == add_ref)
                    else $error("R1 sum or carry");
                p_add_ovf_r1: assert (v_o == ((a_i[MSB] ^ res_o[MSB]) & (b_i[MSB] ^ res_o[MSB])))
                    else $error("R1 overflow");
            end
            if (op_i == 5'd1) begin
                p_sub_diff_r2: assert (res_o == sub_ref && c_o == ({1'b0, a_i} >= sub_need))
                    else $error("R2 difference or borrow");
                p_sub_ovf_r2: assert (v_o == ((a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ res_o[MSB])))
                    else $error("R2 overflow");
            end
            if (op_i == 5'd2) begin
                p_cmp_keep_v_r3: assert (!v_we_o && c_o == (a_i >= b_i))
                    else $error("R3 compare");
            end
            if (op_i == 5'd6) begin
                p_bit_copy_r5: assert (n_o == b_i[MSB] && v_o == b_i[MSB-1] && z_o == ((a_i & b_i) == '0))
                    else $error("R5 bit test");
            end
            if (op_i == 5'd14) begin
                p_move_quiet_r9: assert (!n_we_o && !v_we_o && !z_we_o && !c_we_o)
                    else $error("R9 move raised an enable");
            end
            if (op_i == 5'd18) begin
                p_asr_top_r13: assert (!res_o[MSB] && c_o == (a_i[0] & b_i[0]))
                    else $error("R13 shift of masked value");
            end
            if (op_i > 5'd18) begin
                p_unused_r14: assert (res_o == a_i && !n_we_o && !v_we_o && !z_we_o && !c_we_o)
                    else $error("R14 unused code");
            end
            if (z_we_o) begin
                p_zero_flag_r4: assert (z_o == (res_o == '0))
                    else $error("R4 zero flag");
            end
            if (n_we_o && op_i != 5'd6) begin
                p_neg_flag_r4: assert (n_o == res_o[MSB])
                    else $error("R4 negative flag");
            end
            p_idle_flags_r14: assert ((n_we_o || !n_o) && (v_we_o || !v_o) && (z_we_o || !z_o) && (c_we_o || c_o == c_i))
                else $error("R14 disabled flag value");
        end
    end

endmodule

bind byte_alu byte_alu_chk #(.W(W)) u_chk (
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .x_i    (x_i),
    .c_i    (c_i),
    .res_o  (res_o),
    .n_o    (n_o),
    .v_o    (v_o),
    .z_o    (z_o),
    .c_o    (c_o),
    .n_we_o (n_we_o),
    .v_we_o (v_we_o),
    .z_we_o (z_we_o),
    .c_we_o (c_we_o)
);

// File: tb/sim_byte_alu.sv
`timescale 1ns/1ps
// Bench for byte_alu: a vector table, then sweeps and directed corner checks.
module sim_byte_alu;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [4:0] op;
    logic [7:0] a, b, x;
    logic       cin;
    logic [7:0] res;
    logic       n, v, z, c, nwe, vwe, zwe, cwe;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byte_alu u0 (
        .op_i   (op),
        .a_i    (a),
        .b_i    (b),
        .x_i    (x),
        .c_i    (cin),
        .res_o  (res),
        .n_o    (n),
        .v_o    (v),
        .z_o    (z),
        .c_o    (c),
        .n_we_o (nwe),
        .v_we_o (vwe),
        .z_we_o (zwe),
        .c_we_o (cwe)
    );

    // Vector: op, a, b, x, cin, result, flags {N,V,Z,C}, enables {N,V,Z,C}.
    localparam int NV = 33;
    localparam logic [45:0] VEC [NV] = '{
        {5'd0,  8'h50, 8'h50, 8'h00, 1'b0, 8'hA0, 4'hC, 4'hF},
        {5'd0,  8'hFF, 8'h01, 8'h00, 1'b0, 8'h00, 4'h3, 4'hF},
        {5'd0,  8'h7F, 8'h00, 8'h00, 1'b1, 8'h80, 4'hC, 4'hF},
        {5'd1,  8'h50, 8'hF0, 8'h00, 1'b1, 8'h60, 4'h0, 4'hF},
        {5'd1,  8'h50, 8'hB0, 8'h00, 1'b1, 8'hA0, 4'hC, 4'hF},
        {5'd1,  8'h05, 8'h03, 8'h00, 1'b0, 8'h01, 4'h1, 4'hF},
        {5'd2,  8'h40, 8'h40, 8'h00, 1'b0, 8'h00, 4'h3, 4'hB},
        {5'd2,  8'h10, 8'h20, 8'h00, 1'b1, 8'hF0, 4'h8, 4'hB},
        {5'd3,  8'hF0, 8'h3C, 8'hFF, 1'b1, 8'h30, 4'h1, 4'hA},
        {5'd4,  8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 4'h2, 4'hA},
        {5'd5,  8'hFF, 8'h7F, 8'h00, 1'b0, 8'h80, 4'h8, 4'hA},
        {5'd6,  8'h0F, 8'hC0, 8'h00, 1'b0, 8'h00, 4'hE, 4'hE},
        {5'd6,  8'hFF, 8'h01, 8'h00, 1'b1, 8'h01, 4'h1, 4'hE},
        {5'd7,  8'h00, 8'h81, 8'h00, 1'b0, 8'h02, 4'h1, 4'hB},
        {5'd8,  8'h00, 8'h01, 8'h00, 1'b0, 8'h00, 4'h3, 4'hB},
        {5'd9,  8'h00, 8'h80, 8'h00, 1'b1, 8'h01, 4'h1, 4'hB},
        {5'd10, 8'h00, 8'h01, 8'h00, 1'b1, 8'h80, 4'h9, 4'hB},
        {5'd11, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00, 4'h2, 4'hA},
        {5'd11, 8'h00, 8'h7F, 8'h00, 1'b0, 8'h80, 4'h8, 4'hA},
        {5'd12, 8'h00, 8'h00, 8'h00, 1'b1, 8'hFF, 4'h9, 4'hA},
        {5'd13, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 4'h2, 4'hA},
        {5'd14, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 4'h1, 4'h0},
        {5'd14, 8'h00, 8'h80, 8'h00, 1'b0, 8'h80, 4'h0, 4'h0},
        {5'd15, 8'hFF, 8'h80, 8'h00, 1'b0, 8'h80, 4'h9, 4'hB},
        {5'd15, 8'h0F, 8'hF0, 8'h00, 1'b1, 8'h00, 4'h2, 4'hB},
        {5'd16, 8'hFF, 8'hFF, 8'h00, 1'b1, 8'hFF, 4'h9, 4'hF},
        {5'd16, 8'hFF, 8'h40, 8'h00, 1'b0, 8'h20, 4'h4, 4'hF},
        {5'd17, 8'hF0, 8'h10, 8'h3C, 1'b0, 8'h20, 4'h1, 4'hB},
        {5'd17, 8'hFF, 8'h06, 8'h05, 1'b1, 8'hFF, 4'h8, 4'hB},
        {5'd18, 8'hFF, 8'h03, 8'h00, 1'b0, 8'h01, 4'h1, 4'hB},
        {5'd18, 8'h01, 8'h01, 8'h00, 1'b0, 8'h00, 4'h3, 4'hB},
        {5'd19, 8'h5A, 8'h33, 8'h00, 1'b1, 8'h5A, 4'h1, 4'h0},
        {5'd31, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00, 4'h0, 4'h0}
    };
    localparam string TAG [NV] = '{
        "R1", "R1", "R1", "R2", "R2", "R2", "R3", "R3", "R4", "R4", "R4",
        "R5", "R5", "R6", "R6", "R7", "R7", "R8", "R8", "R8", "R8", "R9",
        "R9", "R10", "R10", "R11", "R11", "R12", "R12", "R13", "R13",
        "R14", "R14"
    };

    // Drive one input set just after a falling edge; outputs settle 1 ns later.
    task automatic apply(input logic [4:0] o, input logic [7:0] aa, input logic [7:0] bb,
                         input logic [7:0] xx, input logic cc);
        @(negedge clk);
        op = o; a = aa; b = bb; x = xx; cin = cc;
        #1;
    endtask

    // Compare all outputs against expected values and record the outcome.
    task automatic check(input string req, input logic [7:0] er, input logic [3:0] ef,
                         input logic [3:0] ew);
        compared++;
        if (res !== er || {n, v, z, c} !== ef || {nwe, vwe, zwe, cwe} !== ew) begin
            mismatched++;
            $display("FAIL %s op=%0d a=%h b=%h x=%h cin=%b: got res=%h flags=%h we=%h, expected res=%h flags=%h we=%h",
                     req, op, a, b, x, cin, res, {n, v, z, c}, {nwe, vwe, zwe, cwe}, er, ef, ew);
        end
    endtask

    // Watchdog: a hung run counts as one mismatch and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        op = '0; a = '0; b = '0; x = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: all-zero inputs give an add of zero (R1).
        apply(5'd0, 8'h00, 8'h00, 8'h00, 1'b0);
        check("R1", 8'h00, 4'h2, 4'hF);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][45:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16]);
            check(TAG[i], VEC[i][15:8], VEC[i][7:4], VEC[i][3:0]);
        end

        // Add, subtract and compare sweeps against the requirement formulas (R1, R2, R3).
        for (int i = 0; i < 256; i++) begin
            for (int k = 0; k < 2; k++) begin
                logic [7:0] aa, bb, rr;
                logic [8:0] s;
                logic       cc, vv, carry;
                aa = 8'(i);
                bb = 8'((i * 37 + 11) & 255);
                cc = k[0];
                s  = {1'b0, aa} + {1'b0, bb} + {8'h00, cc};
                rr = s[7:0];
                vv = ((aa[7] ^ rr[7]) & (bb[7] ^ rr[7]));
                apply(5'd0, aa, bb, 8'h00, cc);
                check("R1", rr, {rr[7], vv, rr == 8'h00, s[8]}, 4'hF);

                rr    = aa - bb - {7'd0, ~cc};
                carry = (int'(aa) >= int'(bb) + (cc ? 0 : 1));
                vv    = ((aa[7] ^ bb[7]) & (aa[7] ^ rr[7]));
                apply(5'd1, aa, bb, 8'h00, cc);
                check("R2", rr, {rr[7], vv, rr == 8'h00, carry}, 4'hF);

                rr = aa - bb;
                apply(5'd2, aa, bb, 8'h00, cc);
                check("R3", rr, {rr[7], 1'b0, rr == 8'h00, aa >= bb}, 4'hB);
            end
        end

        // X input only affects the masked subtract (R12).
        apply(5'd0, 8'h12, 8'h34, 8'hFF, 1'b0);
        check("R12", 8'h46, 4'h0, 4'hF);
        apply(5'd16, 8'hFF, 8'h40, 8'hAA, 1'b0);
        check("R12", 8'h20, 4'h4, 4'hF);
        apply(5'd17, 8'hFF, 8'h00, 8'h00, 1'b0);
        check("R12", 8'h00, 4'h3, 4'hB);

        // Disabled carry repeats carry in for a logic code (R14).
        apply(5'd5, 8'h0F, 8'h0F, 8'h00, 1'b1);
        check("R14", 8'h00, 4'h3, 4'hA);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule